// File: doc/BRIEF.md
# Real-Time Clock Host Access Buffer

This block sits between a byte-wide host register port and the time-of-day counter chain of a real-time clock. It owns the once-per-second update schedule, telling the chain when to advance, and it keeps one host-visible copy byte for every time field. The host reads and writes only these copies. It never touches the live counters directly.

A freeze bit in the mode register takes a coherent snapshot of the live fields and holds the host view still while the chain keeps counting. Host writes mark copy bytes as modified. Once the freeze bit is low, the modified bytes, and only those, are loaded into the chain. The load happens in a cycle outside the warning window that opens a fixed number of cycles before each update, so it can never land on an update. While the block is not frozen, unmodified copies track the chain after every update.

A status bit warns of the coming update. An update-done flag, cleared when it is read, can drive the interrupt output.

Top module: `rtc_shadow_access`

## Requirements
- R1: After reset, the mode register (address NUM_TIME+1) and the flag register (address NUM_TIME+2) read 0x00, every copy byte reads 0x00, and `irq_o`, `uip_o` and `chain_load_o` are low.
- R2: `uip_o` is high for exactly LEAD_CYC consecutive cycles in each second, and the last of those cycles is the update cycle. Bit 7 of the status register (address NUM_TIME) shows the same value.
- R3: `chain_upd_o` is a single-cycle pulse that repeats every CYC_PER_SEC cycles. After reset, the first pulse comes in cycle CYC_PER_SEC-1.
- R4: While the freeze bit (mode bit 7) is 0, every copy byte that has no pending host write takes the chain's value in the second cycle after an update pulse.
- R5: Writing 1 to the freeze bit while it is 0 loads every copy from `chain_time_i` in that cycle. While the bit stays 1, the copies change only through host writes, even as the chain advances.
- R6: A host write to time field i (address i, below NUM_TIME) changes copy byte i at once. While the block is frozen, that write does not reach the chain.
- R7: After the freeze bit is cleared, the chain receives one load. `chain_load_mask_o` in that load has bit i set only for the fields that were written. Fields that were not written keep their live counts.
- R8: `chain_load_o` is never high while `uip_o` or `chain_upd_o` is high, and never while the block is frozen.
- R9: Flag register bit 4 is set in the cycle after each update pulse. A read of the flag register clears it, unless a new update finishes in the same cycle.
- R10: `irq_o` equals flag bit 4 ANDed with enable bit 4 of the mode register. Flag register bit 7 reads as `irq_o`.
- R11: Addresses above NUM_TIME+2 read 0x00, and writes to them change no register and no chain field.
- R12: A host write to a time field while the block is not frozen is loaded into the chain at the first cycle outside the warning window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W (4) | Host register address |
| reg_we_i | input | 1 | Host write strobe |
| reg_re_i | input | 1 | Host read strobe (needed for clear-on-read) |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data, combinational from the address |
| chain_time_i | input | NUM_TIME*8 | Live time fields from the counter chain, field i in byte i |
| chain_upd_o | output | 1 | Once-per-second advance pulse to the chain |
| chain_load_o | output | 1 | Load strobe to the chain |
| chain_load_mask_o | output | NUM_TIME | Per-field load enable |
| chain_load_data_o | output | NUM_TIME*8 | Values to load, field i in byte i |
| uip_o | output | 1 | Update-coming warning |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume a host that does one access per cycle and never holds the read and write strobes together. They also assume a counter chain that applies a load or an advance on the same edge where it sees the strobe. The bench drives every access from its own tasks, one strobe at a time and away from the clock edge. Its chain model advances field 0 on each pulse and applies masked loads. The parameters are scaled to 64 cycles per second with an 8-cycle warning, which keeps LEAD_CYC below CYC_PER_SEC-1 as the window checks require.

// File: rtl/rtc_acc_pkg.sv
`timescale 1ns/1ps
package rtc_acc_pkg;
  typedef logic [7:0] byte_t;

  // bit positions software decodes
  localparam int unsigned UIP_BIT  = 7;
  localparam int unsigned SET_BIT  = 7;
  localparam int unsigned UIE_BIT  = 4;
  localparam int unsigned IRQF_BIT = 7;
  localparam int unsigned UF_BIT   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TIME,
    SEL_STAT,
    SEL_MODE,
    SEL_FLAG
  } reg_sel_e;
endpackage

// File: rtl/rtc_upd_sched.sv
`timescale 1ns/1ps
module rtc_upd_sched #(
  parameter int unsigned CYC_PER_SEC = 32768,
  parameter int unsigned LEAD_CYC    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic upd_o,
  output logic uip_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (CYC_PER_SEC > 2) ? $clog2(CYC_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST       = CNT_W'(CYC_PER_SEC - 1);
  localparam logic [CNT_W-1:0] LEAD_START = CNT_W'(CYC_PER_SEC - LEAD_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      done_q <= upd_o;
    end
  end

  assign upd_o  = (cnt_q == LAST);
  assign uip_o  = (cnt_q >= LEAD_START);
  assign done_o = done_q;
endmodule

// File: rtl/rtc_ctrl_regs.sv
`timescale 1ns/1ps
module rtc_ctrl_regs
  import rtc_acc_pkg::*;
#(
  parameter int unsigned NUM_TIME = 6,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic                    wset_i,
  input  logic                    wuie_i,
  input  logic                    uip_i,
  input  logic                    done_i,
  input  logic [NUM_TIME*8-1:0]   copies_i,
  output logic                    set_o,
  output logic                    snap_o,
  output logic                    uf_o,
  output logic                    irq_o,
  output logic                    time_wr_o,
  output logic [IDX_W-1:0]        time_idx_o,
  output byte_t                   rdata_o
);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(NUM_TIME);
  localparam logic [ADDR_W-1:0] ADDR_MODE = ADDR_W'(NUM_TIME + 1);
  localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(NUM_TIME + 2);

  reg_sel_e sel;
  logic     set_q, uie_q, uf_q;
  logic     mode_wr, flag_rd;

  always_comb begin
    if (addr_i < ADDR_STAT)       sel = SEL_TIME;
    else if (addr_i == ADDR_STAT) sel = SEL_STAT;
    else if (addr_i == ADDR_MODE) sel = SEL_MODE;
    else if (addr_i == ADDR_FLAG) sel = SEL_FLAG;
    else                          sel = SEL_NONE;
  end

  assign time_idx_o = addr_i[IDX_W-1:0];
  assign time_wr_o  = we_i && (sel == SEL_TIME);
  assign mode_wr    = we_i && (sel == SEL_MODE);
  assign flag_rd    = re_i && (sel == SEL_FLAG);
  assign snap_o     = mode_wr && wset_i && !set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= 1'b0;
      uie_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      if (mode_wr) begin
        set_q <= wset_i;
        uie_q <= wuie_i;
      end
      // a finishing update outranks the read clear
      if (done_i)       uf_q <= 1'b1;
      else if (flag_rd) uf_q <= 1'b0;
    end
  end

  assign set_o = set_q;
  assign uf_o  = uf_q;
  assign irq_o = uf_q && uie_q;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_TIME: rdata_o = copies_i[32'(time_idx_o)*8 +: 8];
      SEL_STAT: rdata_o[UIP_BIT] = uip_i;
      SEL_MODE: begin
        rdata_o[SET_BIT] = set_q;
        rdata_o[UIE_BIT] = uie_q;
      end
      SEL_FLAG: begin
        rdata_o[IRQF_BIT] = irq_o;
        rdata_o[UF_BIT]   = uf_q;
      end
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_copy_bank.sv
`timescale 1ns/1ps
module rtc_copy_bank
  import rtc_acc_pkg::*;
#(
  parameter int unsigned NUM_TIME = 6,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  snap_i,
  input  logic                  set_i,
  input  logic                  follow_i,
  input  logic                  blocked_i,
  input  logic                  wr_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  byte_t                 wr_data_i,
  input  logic [NUM_TIME*8-1:0] chain_time_i,
  output logic [NUM_TIME*8-1:0] copies_o,
  output logic                  load_o,
  output logic [NUM_TIME-1:0]   load_mask_o,
  output logic [NUM_TIME*8-1:0] load_data_o
);
  logic [NUM_TIME-1:0] dirty;

  // commit only modified fields, never inside the warning window
  assign load_o      = !set_i && (|dirty) && !blocked_i;
  assign load_mask_o = load_o ? dirty : '0;

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_field
    byte_t copy_q;
    logic  dirty_q;
    logic  hit;

    assign hit = wr_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        copy_q  <= '0;
        dirty_q <= 1'b0;
      end else if (snap_i) begin
        copy_q  <= chain_time_i[i*8 +: 8];
        dirty_q <= 1'b0;
      end else if (hit) begin
        copy_q  <= wr_data_i;
        dirty_q <= 1'b1;
      end else begin
        if (load_o) dirty_q <= 1'b0;
        if (follow_i && !dirty_q) copy_q <= chain_time_i[i*8 +: 8];
      end
    end

    assign dirty[i]              = dirty_q;
    assign copies_o[i*8 +: 8]    = copy_q;
    assign load_data_o[i*8 +: 8] = copy_q;
  end
endmodule

// File: rtl/rtc_shadow_access.sv
`timescale 1ns/1ps
module rtc_shadow_access
  import rtc_acc_pkg::*;
#(
  parameter int unsigned NUM_TIME    = 6,
  parameter int unsigned CYC_PER_SEC = 32768,
  parameter int unsigned LEAD_CYC    = 8,
  parameter int unsigned ADDR_W      = $clog2(NUM_TIME + 3)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_we_i,
  input  logic                  reg_re_i,
  input  logic [7:0]            reg_wdata_i,
  output logic [7:0]            reg_rdata_o,
  input  logic [NUM_TIME*8-1:0] chain_time_i,
  output logic                  chain_upd_o,
  output logic                  chain_load_o,
  output logic [NUM_TIME-1:0]   chain_load_mask_o,
  output logic [NUM_TIME*8-1:0] chain_load_data_o,
  output logic                  uip_o,
  output logic                  irq_o
);
  localparam int unsigned IDX_W = (NUM_TIME > 1) ? $clog2(NUM_TIME) : 1;

  logic                  done_w, set_w, snap_w, uf_w, time_wr_w;
  logic [IDX_W-1:0]      time_idx_w;
  logic [NUM_TIME*8-1:0] copies_w;

  rtc_upd_sched #(
    .CYC_PER_SEC(CYC_PER_SEC),
    .LEAD_CYC   (LEAD_CYC)
  ) i_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_o  (chain_upd_o),
    .uip_o  (uip_o),
    .done_o (done_w)
  );

  rtc_ctrl_regs #(
    .NUM_TIME(NUM_TIME),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .we_i       (reg_we_i),
    .re_i       (reg_re_i),
    .wset_i     (reg_wdata_i[SET_BIT]),
    .wuie_i     (reg_wdata_i[UIE_BIT]),
    .uip_i      (uip_o),
    .done_i     (done_w),
    .copies_i   (copies_w),
    .set_o      (set_w),
    .snap_o     (snap_w),
    .uf_o       (uf_w),
    .irq_o      (irq_o),
    .time_wr_o  (time_wr_w),
    .time_idx_o (time_idx_w),
    .rdata_o    (reg_rdata_o)
  );

  rtc_copy_bank #(
    .NUM_TIME(NUM_TIME),
    .IDX_W   (IDX_W)
  ) i_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .snap_i       (snap_w),
    .set_i        (set_w),
    .follow_i     (done_w && !set_w),
    .blocked_i    (uip_o),
    .wr_i         (time_wr_w),
    .wr_idx_i     (time_idx_w),
    .wr_data_i    (reg_wdata_i),
    .chain_time_i (chain_time_i),
    .copies_o     (copies_w),
    .load_o       (chain_load_o),
    .load_mask_o  (chain_load_mask_o),
    .load_data_o  (chain_load_data_o)
  );
endmodule

// File: rtl/rtc_shadow_access_chk.sv
`timescale 1ns/1ps
module rtc_shadow_access_chk #(
  parameter int unsigned NUM_TIME = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  upd_i,
  input logic                  uip_i,
  input logic                  load_i,
  input logic                  set_i,
  input logic                  done_i,
  input logic                  uf_i,
  input logic                  time_wr_i,
  input logic [NUM_TIME*8-1:0] copies_i
);
  assert_upd_in_lead_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> uip_i);

  assert_uip_drops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !uip_i);

  assert_upd_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i);

  assert_load_outside_lead_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!uip_i && !upd_i));

  assert_load_unfrozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !set_i);

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && $past(set_i) && !$past(time_wr_i)) |-> $stable(copies_i));

  assert_flag_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uf_i) |-> $past(done_i));
endmodule

bind rtc_shadow_access rtc_shadow_access_chk #(
  .NUM_TIME(NUM_TIME)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .upd_i     (chain_upd_o),
  .uip_i     (uip_o),
  .load_i    (chain_load_o),
  .set_i     (set_w),
  .done_i    (done_w),
  .uf_i      (uf_w),
  .time_wr_i (time_wr_w),
  .copies_i  (copies_w)
);

// File: tb/test_rtc_shadow_access.sv
`timescale 1ns/1ps
module test_rtc_shadow_access;
  localparam int unsigned NUM_TIME = 6;
  localparam int unsigned CPS      = 64;
  localparam int unsigned LEAD     = 8;
  localparam int unsigned ADDR_W   = $clog2(NUM_TIME + 3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_TIME);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(NUM_TIME + 1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NUM_TIME + 2);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [ADDR_W-1:0]     addr = '0;
  logic                  we = 1'b0, re = 1'b0;
  logic [7:0]            wdata = '0, rdata;
  logic [NUM_TIME*8-1:0] chain_flat, load_data;
  logic                  upd, load, uip, irq;
  logic [NUM_TIME-1:0]   load_mask;
  logic [7:0]            chain_q [NUM_TIME];

  int n_cmp = 0, n_bad = 0, n_load = 0, n_coll = 0;
  logic [NUM_TIME-1:0] last_mask = '0;

  always #2 clk = ~clk;

  rtc_shadow_access #(
    .NUM_TIME   (NUM_TIME),
    .CYC_PER_SEC(CPS),
    .LEAD_CYC   (LEAD)
  ) i_rtc_shadow_access (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .reg_addr_i        (addr),
    .reg_we_i          (we),
    .reg_re_i          (re),
    .reg_wdata_i       (wdata),
    .reg_rdata_o       (rdata),
    .chain_time_i      (chain_flat),
    .chain_upd_o       (upd),
    .chain_load_o      (load),
    .chain_load_mask_o (load_mask),
    .chain_load_data_o (load_data),
    .uip_o             (uip),
    .irq_o             (irq)
  );

  // counter chain model: field 0 advances, masked loads apply
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_TIME; k++) chain_q[k] <= 8'(16 * k);
    end else begin
      if (upd) chain_q[0] <= chain_q[0] + 8'd1;
      for (int k = 0; k < NUM_TIME; k++)
        if (load && load_mask[k]) chain_q[k] <= load_data[k*8 +: 8];
    end
  end

  always_comb
    for (int k = 0; k < NUM_TIME; k++) chain_flat[k*8 +: 8] = chain_q[k];

  always @(negedge clk) begin
    if (rst_n && load) begin
      n_load++;
      last_mask = load_mask;
      if (uip || upd) n_coll++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wait_upd();
    @(negedge clk);
    while (!upd) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", irq, 0);
    chk("R1 uip", uip, 0);
    chk("R1 load", load, 0);
    rd(A_MODE, v); chk("R1 mode", v, 8'h00);
    rd(A_FLAG, v); chk("R1 flag", v, 8'h00);
    rd(0, v);      chk("R1 copy0", v, 8'h00);
  endtask

  task automatic t_window();
    int first = 0, pulse = 0;
    logic [7:0] v;
    wait_upd();
    for (int n = 1; n <= int'(CPS); n++) begin
      @(negedge clk);
      if (uip && first == 0) first = n;
      if (upd && pulse == 0) pulse = n;
    end
    chk("R3 period", pulse, CPS);
    chk("R2 uip start", first, CPS - LEAD + 1);
    @(negedge clk);
    chk("R2 uip low after update", uip, 0);
    @(negedge clk);
    while (!uip) @(negedge clk);
    rd(A_STAT, v); chk("R2 status bit in window", v, 8'h80);
    wait_upd(); settle();
    rd(A_STAT, v); chk("R2 status bit outside", v, 8'h00);
  endtask

  task automatic t_follow();
    logic [7:0] v;
    wait_upd(); settle();
    rd(0, v); chk("R4 copy tracks chain", v, chain_q[0]);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    rd(A_FLAG, v);
    wait_upd(); settle();
    chk("R10 irq masked", irq, 0);
    rd(A_FLAG, v); chk("R9 flag set", v, 8'h10);
    rd(A_FLAG, v); chk("R9 read clears", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(A_MODE, 8'h10);
    rd(A_FLAG, v);
    wait_upd(); settle();
    chk("R10 irq raised", irq, 1);
    rd(A_FLAG, v); chk("R10 flag irq bit", v, 8'h90);
    chk("R10 irq cleared", irq, 0);
    wr(A_MODE, 8'h00);
  endtask

  task automatic t_freeze_commit();
    logic [7:0] v, s;
    int loads0;
    wait_upd(); settle();
    s = chain_q[0];
    wr(A_MODE, 8'h80);
    rd(0, v); chk("R5 snapshot", v, s);
    wait_upd(); settle();
    rd(0, v); chk("R5 frozen copy", v, s);
    chk("R5 chain advanced", chain_q[0], s + 8'd1);
    loads0 = n_load;
    wr(1, 8'h5A);
    rd(1, v); chk("R6 copy written", v, 8'h5A);
    repeat (6) @(negedge clk);
    chk("R6 chain untouched", chain_q[1], 8'h10);
    chk("R6 no load while frozen", n_load, loads0);
    wr(A_MODE, 8'h00);
    repeat (LEAD + 4) @(negedge clk);
    chk("R7 field loaded", chain_q[1], 8'h5A);
    chk("R7 one load", n_load, loads0 + 1);
    chk("R7 mask", last_mask, 6'b000010);
    chk("R7 unwritten field kept", chain_q[0], s + 8'd1);
  endtask

  task automatic t_live_write();
    logic [7:0] v;
    int loads0;
    @(negedge clk);
    while (uip) @(negedge clk);
    while (!uip) @(negedge clk);
    loads0 = n_load;
    wr(2, 8'h33);
    chk("R12 held in window", n_load, loads0);
    chk("R12 chain not yet", chain_q[2], 8'h20);
    wait_upd(); settle();
    chk("R12 loaded after update", chain_q[2], 8'h33);
    chk("R12 single load", n_load, loads0 + 1);
    rd(2, v); chk("R12 copy keeps value", v, 8'h33);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(ADDR_W'(15), 8'hFF);
    rd(ADDR_W'(15), v); chk("R11 unmapped reads zero", v, 8'h00);
    rd(A_MODE, v);      chk("R11 mode untouched", v, 8'h00);
    repeat (LEAD + 4) @(negedge clk);
    chk("R11 chain field 5 untouched", chain_q[5], 8'h50);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_follow();
    t_flag();
    t_irq();
    t_freeze_commit();
    t_live_write();
    t_unmapped();
    chk("R8 no load in window", n_coll, 0);
    report();
  end
endmodule